// File: doc/BRIEF.md
# Clock Mode and Lock Status Controller

This block keeps the clock-configuration state of a chip. Software writes a 3-bit clock-mode code. The block tracks whether the PLL behind that code has locked. It raises a PLL interrupt request whenever a write moves the chip to a new PLL mode, because that write throws away the current lock. The PLL request uses one interrupt node together with a real-time-clock tick. A small subnode register gives each of the two sources its own request bit and its own enable bit.

The analog PLL is not modelled. A lock indicator input stands in for it, and the block declares lock only after that indicator has stayed high for a programmable number of reference cycles. An oscillator-watchdog input reports a missing oscillator. The block then flags that the PLL base clock is being substituted, and also flags when that base clock must be halved because the prescaler mode is selected. Clock multiplication and glitch-free muxing lie outside this block. It only presents the selected mode code and the status flags.

The lock tracker is a state machine with three states:
- `ST_BYPASS` is used for modes without a PLL.
- `ST_ACQUIRE` counts stable lock cycles.
- `ST_LOCKED` reports lock.

Its transitions are:
- A mode write with a new PLL code goes from any state to `ST_ACQUIRE`.
- A mode write with a new non-PLL code goes from any state to `ST_BYPASS`.
- `ST_ACQUIRE` goes to `ST_LOCKED` when the count is reached.
- `ST_ACQUIRE` stays in `ST_ACQUIRE` with the count cleared when the lock input drops.
- `ST_LOCKED` and `ST_BYPASS` hold until the next mode write that changes the code.

Top module: `clk_mode_ctrl`

## Requirements
- R1: A mode write whose data differs from the current mode and is a PLL code (anything except 001 and 011) has these effects after that clock edge: the mode output takes the new code, the lock flag is 0, and the PLL request bit (subnode bit 0) is 1.
- R2: A mode write whose data equals the current mode changes nothing. The mode, the lock flag and the subnode bits keep their values, and a completed lock stays reported.
- R3: Code 001 (direct drive) and code 011 (prescaler) never report lock, whatever the lock input does. A write that changes to one of these codes does not set the PLL request.
- R4: After a change to a PLL code, the lock flag rises after the N-th consecutive clock edge at which the lock input is high, where N is `lock_target`. A `lock_target` of 0 behaves as 1.
- R5: If the lock input is low at any edge during acquisition, the count of stable cycles starts again from zero.
- R6: The fallback flag follows the inverse of `osc_ok`, one clock edge later. The halve flag is 1 exactly when the fallback flag is 1 and the mode is 011.
- R7: Subnode layout: bit 0 is the PLL request, bit 1 is the PLL enable, bit 2 is the RTC request and bit 3 is the RTC enable. A subnode write loads all four bits. The node request is (bit0 AND bit1) OR (bit2 AND bit3). Writing the request and enable bits to 0 and then setting the enable bit again leaves the source clear.
- R8: A hardware request from a mode change or from `rtc_tick` in the same cycle as a subnode write that clears that request bit leaves the bit set.
- R9: After reset, the mode is 001, the lock flag is 0, all subnode bits are 0, and the node request and both fallback flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the lock reference |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Clock-mode write strobe |
| mode_wdata | input | 3 | Clock-mode code to write |
| pll_lock_in | input | 1 | Lock indicator from the PLL |
| lock_target | input | CNT_W | Stable cycles needed before lock is declared |
| osc_ok | input | 1 | Oscillator watchdog: 1 while the oscillator runs |
| rtc_tick | input | 1 | Request pulse from the real-time clock |
| sub_wr | input | 1 | Subnode register write strobe |
| sub_wdata | input | 4 | Subnode register write data |
| mode_q | output | 3 | Currently selected clock-mode code |
| pll_locked | output | 1 | PLL lock status |
| sub_q | output | 4 | Subnode register contents |
| irq_node | output | 1 | Shared interrupt node request |
| osc_fallback | output | 1 | Base clock substituted for a missing oscillator |
| fallback_div2 | output | 1 | Substituted base clock is halved (prescaler mode) |

## Verification
The hardest case to reach is a software clear of a request bit landing on the same edge as a hardware set of that bit. For the PLL source this means a subnode write and a mode-changing write in one cycle. A close second is an acquisition count that is broken one cycle before it completes. Directed sequences place both cases exactly: a clearing subnode write alongside an RTC tick and alongside a new PLL code, and a lock input that drops on the third of four required cycles. A long seeded random run then mixes frequent mode writes, subnode writes, ticks, small lock targets and a flickering lock input, so that these coincidences also occur at random phases. Every cycle of that run is compared against a bench model.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;
    typedef enum logic [1:0] {
        ST_BYPASS  = 2'd0,
        ST_ACQUIRE = 2'd1,
        ST_LOCKED  = 2'd2
    } lock_state_e;

    localparam logic [2:0] MODE_DIRECT   = 3'b001;
    localparam logic [2:0] MODE_PRESCALE = 3'b011;

    function automatic logic mode_uses_pll(input logic [2:0] m);
        return (m != MODE_DIRECT) && (m != MODE_PRESCALE);
    endfunction
endpackage

// File: rtl/clk_lock_fsm.sv
module clk_lock_fsm
    import clk_mode_pkg::*;
#(
    parameter int         CNT_W      = 8,
    parameter logic [2:0] RESET_MODE = MODE_DIRECT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [2:0]       mode_wdata,
    input  logic             lock_in,
    input  logic [CNT_W-1:0] lock_target,
    output logic [2:0]       mode_q,
    output logic             locked,
    output logic             pll_set
);
    localparam lock_state_e RST_STATE = mode_uses_pll(RESET_MODE) ? ST_ACQUIRE : ST_BYPASS;

    lock_state_e      state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [2:0]       mode_n;
    logic [CNT_W:0]   cnt_inc, tgt_eff;
    logic             mode_change;

    assign mode_change = mode_wr && (mode_wdata != mode_q);
    assign cnt_inc     = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
    assign tgt_eff     = (lock_target == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, lock_target};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RST_STATE;
            cnt    <= '0;
            mode_q <= RESET_MODE;
        end else begin
            state  <= state_n;
            cnt    <= cnt_n;
            mode_q <= mode_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        mode_n  = mode_q;
        if (mode_change) begin
            mode_n  = mode_wdata;
            cnt_n   = '0;
            state_n = mode_uses_pll(mode_wdata) ? ST_ACQUIRE : ST_BYPASS;
        end else begin
            unique case (state)
                ST_BYPASS: ;
                ST_ACQUIRE: begin
                    if (lock_in) begin
                        if (cnt_inc >= tgt_eff) state_n = ST_LOCKED;
                        else                    cnt_n   = cnt_inc[CNT_W-1:0];
                    end else begin
                        cnt_n = '0;
                    end
                end
                ST_LOCKED: ;
                default: state_n = ST_BYPASS;
            endcase
        end
    end

    // outputs
    always_comb begin
        locked  = (state == ST_LOCKED);
        pll_set = mode_change && mode_uses_pll(mode_wdata);
    end

    assert_lock_needs_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(lock_in));
    assert_count_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACQUIRE && !lock_in && !mode_wr) |=> (cnt == '0 && !locked));
    assert_same_write_keeps_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_wdata == mode_q && locked) |=> locked);
endmodule

// File: rtl/clk_irq_subnode.sv
module clk_irq_subnode #(
    parameter int NSRC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   hw_set,
    input  logic              sub_wr,
    input  logic [2*NSRC-1:0] sub_wdata,
    output logic [2*NSRC-1:0] sub_q,
    output logic              irq_node
);
    logic [NSRC-1:0] req, en, live;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req[i] <= 1'b0;
                en[i]  <= 1'b0;
            end else begin
                // hardware set wins over a software clear in the same cycle
                req[i] <= hw_set[i] | (sub_wr ? sub_wdata[2*i] : req[i]);
                if (sub_wr) en[i] <= sub_wdata[2*i+1];
            end
        end
        assign sub_q[2*i]   = req[i];
        assign sub_q[2*i+1] = en[i];
        assign live[i]      = req[i] & en[i];

        assert_hw_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            hw_set[i] |=> req[i]);
    end

    assign irq_node = |live;
endmodule

// File: rtl/clk_osc_fallback.sv
module clk_osc_fallback
    import clk_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_ok,
    input  logic [2:0] mode_q,
    output logic       fallback,
    output logic       div2
);
    always_ff @(posedge clk) begin
        if (!rst_n) fallback <= 1'b0;
        else        fallback <= !osc_ok;
    end

    assign div2 = fallback && (mode_q == MODE_PRESCALE);
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
    import clk_mode_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [2:0]       mode_wdata,
    input  logic             pll_lock_in,
    input  logic [CNT_W-1:0] lock_target,
    input  logic             osc_ok,
    input  logic             rtc_tick,
    input  logic             sub_wr,
    input  logic [3:0]       sub_wdata,
    output logic [2:0]       mode_q,
    output logic             pll_locked,
    output logic [3:0]       sub_q,
    output logic             irq_node,
    output logic             osc_fallback,
    output logic             fallback_div2
);
    localparam int NSRC = 2;

    logic pll_set;

    clk_lock_fsm #(.CNT_W(CNT_W), .RESET_MODE(MODE_DIRECT)) u_lock (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .lock_in(pll_lock_in), .lock_target(lock_target),
        .mode_q(mode_q), .locked(pll_locked), .pll_set(pll_set)
    );

    clk_irq_subnode #(.NSRC(NSRC)) u_sub (
        .clk(clk), .rst_n(rst_n), .hw_set({rtc_tick, pll_set}),
        .sub_wr(sub_wr), .sub_wdata(sub_wdata), .sub_q(sub_q), .irq_node(irq_node)
    );

    clk_osc_fallback u_osc (
        .clk(clk), .rst_n(rst_n), .osc_ok(osc_ok), .mode_q(mode_q),
        .fallback(osc_fallback), .div2(fallback_div2)
    );

    assert_bypass_never_locks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_uses_pll(mode_q) |-> !pll_locked);
    assert_new_pll_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_wdata != mode_q && mode_uses_pll(mode_wdata))
        |=> (!pll_locked && sub_q[0] && mode_q == $past(mode_wdata)));
    assert_same_mode_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_wdata == mode_q && !sub_wr) |=> ($stable(mode_q) && $stable(sub_q[1:0])));
endmodule

// File: tb/sim_clk_mode_ctrl.sv
`timescale 1ns/1ps
module sim_clk_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [2:0] mode_wdata = 3'b000;
    logic       pll_lock_in = 1'b0;
    logic [7:0] lock_target = 8'd1;
    logic       osc_ok = 1'b1;
    logic       rtc_tick = 1'b0;
    logic       sub_wr = 1'b0;
    logic [3:0] sub_wdata = 4'b0000;
    logic [2:0] mode_q;
    logic       pll_locked, irq_node, osc_fallback, fallback_div2;
    logic [3:0] sub_q;

    always #2.5 clk = ~clk;

    clk_mode_ctrl #(.CNT_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .pll_lock_in(pll_lock_in), .lock_target(lock_target), .osc_ok(osc_ok),
        .rtc_tick(rtc_tick), .sub_wr(sub_wr), .sub_wdata(sub_wdata),
        .mode_q(mode_q), .pll_locked(pll_locked), .sub_q(sub_q), .irq_node(irq_node),
        .osc_fallback(osc_fallback), .fallback_div2(fallback_div2)
    );

    int   errs = 0;
    int   checks = 0;
    bit   done = 1'b0;
    // bench model: 0 bypass, 1 acquiring, 2 locked
    logic [2:0] m_mode;
    int         m_st, m_cnt;
    logic [3:0] m_sub;
    logic       m_fb;

    function automatic bit is_pll(input logic [2:0] m);
        return (m != 3'b001) && (m != 3'b011);
    endfunction

    function automatic logic exp_irq(input logic [3:0] s);
        return (s[0] & s[1]) | (s[2] & s[3]);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_mode = 3'b001; m_st = 0; m_cnt = 0; m_sub = 4'b0000; m_fb = 1'b0;
    endtask

    task automatic model_edge();
        int  tgt;
        bit  pset;
        logic [3:0] ns;
        tgt  = (lock_target == 0) ? 1 : int'(lock_target);
        pset = mode_wr && (mode_wdata != m_mode) && is_pll(mode_wdata);
        if (mode_wr && mode_wdata != m_mode) begin
            m_mode = mode_wdata;
            m_st   = is_pll(mode_wdata) ? 1 : 0;
            m_cnt  = 0;
        end else if (m_st == 1) begin
            if (pll_lock_in) begin
                if (m_cnt + 1 >= tgt) m_st = 2;
                else m_cnt++;
            end else m_cnt = 0;
        end
        for (int i = 0; i < 2; i++) begin
            bit hw;
            hw = (i == 0) ? pset : rtc_tick;
            ns[2*i]   = hw | (sub_wr ? sub_wdata[2*i] : m_sub[2*i]);
            ns[2*i+1] = sub_wr ? sub_wdata[2*i+1] : m_sub[2*i+1];
        end
        m_sub = ns;
        m_fb  = !osc_ok;
    endtask

    task automatic compare_all();
        chk("R4 lock", {31'd0, pll_locked}, {31'd0, (m_st == 2)});
        chk("R2 mode", {29'd0, mode_q}, {29'd0, m_mode});
        chk("R8 subnode", {28'd0, sub_q}, {28'd0, m_sub});
        chk("R7 node", {31'd0, irq_node}, {31'd0, exp_irq(m_sub)});
        chk("R6 fallback", {31'd0, osc_fallback}, {31'd0, m_fb});
        chk("R6 halve", {31'd0, fallback_div2}, {31'd0, m_fb && m_mode == 3'b011});
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        #1;
        compare_all();
        @(negedge clk);
        mode_wr = 1'b0; sub_wr = 1'b0; rtc_tick = 1'b0;
    endtask

    task automatic wr_mode(input logic [2:0] m);
        mode_wr = 1'b1; mode_wdata = m; cyc();
    endtask

    task automatic wr_sub(input logic [3:0] d);
        sub_wr = 1'b1; sub_wdata = d; cyc();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errs++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd52817));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.1;
        // R9 reset state
        chk("R9 mode", {29'd0, mode_q}, 32'd1);
        chk("R9 lock", {31'd0, pll_locked}, 32'd0);
        chk("R9 sub", {28'd0, sub_q}, 32'd0);
        chk("R9 node", {31'd0, irq_node}, 32'd0);
        chk("R9 fallback", {30'd0, osc_fallback, fallback_div2}, 32'd0);

        // R3: bypass codes never lock
        pll_lock_in = 1'b1; lock_target = 8'd2;
        repeat (6) cyc();
        chk("R3 direct lock", {31'd0, pll_locked}, 32'd0);
        wr_mode(3'b011);
        chk("R3 no request", {31'd0, sub_q[0]}, 32'd0);
        repeat (6) cyc();
        chk("R3 prescale lock", {31'd0, pll_locked}, 32'd0);

        // R1 then R4 with target 3
        lock_target = 8'd3;
        wr_mode(3'b100);
        chk("R1 lock cleared", {31'd0, pll_locked}, 32'd0);
        chk("R1 request", {31'd0, sub_q[0]}, 32'd1);
        chk("R1 mode", {29'd0, mode_q}, 32'h4);
        cyc(); cyc();
        chk("R4 early", {31'd0, pll_locked}, 32'd0);
        cyc();
        chk("R4 locked", {31'd0, pll_locked}, 32'd1);

        // R2: same mode rewrite
        wr_sub(4'b0000);
        wr_mode(3'b100);
        chk("R2 lock kept", {31'd0, pll_locked}, 32'd1);
        chk("R2 request", {28'd0, sub_q}, 32'd0);

        // R1 from locked
        wr_mode(3'b110);
        chk("R1 lock lost", {31'd0, pll_locked}, 32'd0);
        chk("R1 request again", {31'd0, sub_q[0]}, 32'd1);

        // R5: target 4, break on third cycle
        lock_target = 8'd4;
        wr_mode(3'b111);
        cyc(); cyc();
        pll_lock_in = 1'b0; cyc();
        pll_lock_in = 1'b1; cyc(); cyc(); cyc();
        chk("R5 restarted", {31'd0, pll_locked}, 32'd0);
        cyc();
        chk("R5 locked", {31'd0, pll_locked}, 32'd1);

        // R4: target 0 acts as 1
        lock_target = 8'd0;
        wr_mode(3'b000);
        cyc();
        chk("R4 target zero", {31'd0, pll_locked}, 32'd1);

        // R7: enable, clear sequence
        wr_sub(4'b0011);
        chk("R7 node up", {31'd0, irq_node}, 32'd1);
        wr_sub(4'b0000);
        wr_sub(4'b0010);
        chk("R7 cleared", {28'd0, sub_q}, 32'h2);
        chk("R7 node down", {31'd0, irq_node}, 32'd0);

        // R8: simultaneous set and clear
        wr_sub(4'b1010);
        sub_wr = 1'b1; sub_wdata = 4'b1010; rtc_tick = 1'b1; cyc();
        chk("R8 rtc kept", {31'd0, sub_q[2]}, 32'd1);
        chk("R8 rtc node", {31'd0, irq_node}, 32'd1);
        sub_wr = 1'b1; sub_wdata = 4'b0000; mode_wr = 1'b1; mode_wdata = 3'b101; cyc();
        chk("R8 pll kept", {28'd0, sub_q}, 32'h1);

        // R6: oscillator loss
        wr_mode(3'b011);
        osc_ok = 1'b0; cyc();
        chk("R6 fallback", {31'd0, osc_fallback}, 32'd1);
        chk("R6 halve", {31'd0, fallback_div2}, 32'd1);
        wr_mode(3'b010);
        chk("R6 no halve", {31'd0, fallback_div2}, 32'd0);
        osc_ok = 1'b1; cyc();
        chk("R6 restored", {31'd0, osc_fallback}, 32'd0);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            mode_wr     = ($urandom % 8) == 0;
            mode_wdata  = 3'($urandom % 8);
            sub_wr      = ($urandom % 8) == 0;
            sub_wdata   = 4'($urandom % 16);
            rtc_tick    = ($urandom % 10) == 0;
            pll_lock_in = ($urandom % 6) != 0;
            osc_ok      = ($urandom % 12) != 0;
            if (($urandom % 50) == 0) lock_target = 8'($urandom % 6);
            cyc();
        end
        finish_run();
    end
endmodule